// File: doc/BRIEF.md
# Serial Flash Slave Port Front-End

This block sits between the four or five pins of a serial-flash-style SPI port and the command decoder of a flash device. All pins are brought into the system clock domain. The block finds serial clock edges there and captures one input bit on every rising edge, most significant bit first. On every falling edge it moves the output line to its next bit. Chip select frames each instruction. The output is enabled only while the device is selected and not paused.

The decoder receives every completed byte with a one-cycle valid strobe. It also gets a one-cycle strobe when a frame opens and another when a frame closes part way through a byte. The decoder supplies the byte to send next. The block also holds the two block-protect bits of the status register. These bits change only on a status write made while the write-protect pin is inactive.

A hold input pauses a transfer in the middle of a byte. During the pause the output is released and the clock and data pins are ignored. The bit position is kept, so the byte continues where it stopped. After reset the port refuses every frame until chip select has been seen high and then falls. A select line that is already low when power comes up therefore cannot start an instruction.

Top module: `sflash_port_fe`

## Requirements
- R1: Input bits are captured on rising serial-clock edges, most significant bit first. After each eighth captured bit of a frame, `rx_byte_o` holds the byte and `rx_valid_o` pulses for one cycle.
- R2: `miso_o` changes only after a falling serial-clock edge and stays stable while the serial clock is high. During the first byte of a frame it reads 0. During each later byte it sends, MSB first, the value `tx_byte_i` had at the falling edge that closed the previous byte.
- R3: `miso_oe_o` is low whenever `cs_n_i` is high, so the output is high impedance while the device is deselected.
- R4: `standby_o` is 1 exactly when `cs_n_i` is high and `busy_i` is low. It is 0 while selected or while an internal cycle is running.
- R5: After reset, no frame is accepted until `cs_n_i` has been high and then falls. If `cs_n_i` is low from reset, clock pulses produce no `frame_start_o`, no `rx_valid_o` and no output enable.
- R6: Each accepted falling edge of `cs_n_i` pulses `frame_start_o` once and restarts bit counting, so the next eight bits form a whole byte.
- R7: While `hold_n_i` is low with the device selected and the serial clock low, `miso_oe_o` is low and serial clock and data edges are ignored. After `hold_n_i` rises (serial clock low), the byte continues from the same bit position.
- R8: `hold_n_i` low while deselected has no effect: `standby_o` stays 1, `miso_oe_o` stays 0 and no byte is reported.
- R9: `cs_n_i` rising after 1 to 7 bits of a byte pulses `frame_abort_o` and reports no byte. Rising on a byte boundary gives no abort.
- R10: A pulse on `sr_wr_i` loads `sr_bp_i` into `bp_o` when `wp_n_i` is high. When `wp_n_i` is low, `bp_o` keeps its value.
- R11: After reset `bp_o` is 0, `miso_oe_o` is 0 and the three strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin |
| mosi_i | input | 1 | Serial data into the device |
| cs_n_i | input | 1 | Chip select, active low |
| hold_n_i | input | 1 | Transfer pause, active low |
| wp_n_i | input | 1 | Write protect, active low |
| miso_o | output | 1 | Serial data out of the device |
| miso_oe_o | output | 1 | Output enable for the serial data-out pad |
| busy_i | input | 1 | Internal program, erase or status-write cycle running |
| standby_o | output | 1 | Deselected and idle |
| tx_byte_i | input | BYTE_W | Next byte to shift out |
| rx_byte_o | output | BYTE_W | Last completed received byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| frame_start_o | output | 1 | One-cycle strobe at an accepted select |
| frame_abort_o | output | 1 | One-cycle strobe when a frame ends mid-byte |
| sr_wr_i | input | 1 | Status write strobe from the decoder |
| sr_bp_i | input | BP_W | Block-protect value to write |
| bp_o | output | BP_W | Current block-protect bits |

## Verification
The hardest case to reach is a hold taken in the middle of a byte. To show that the bit position survives, the pause must fall between two particular clock edges. The ignored clock pulses during the pause must also leave no trace. The bench puts a hold point into its byte-transfer task. There it lowers hold with the clock low, toggles the clock and data several times, and then releases hold. It then checks that the received byte and the returned byte are both intact. A second difficult case is a select line held low from reset. The bench starts in that state and clocks a full byte before first raising select.

// File: rtl/sfp_pkg.sv
package sfp_pkg;

    typedef struct packed {
        logic sclk;
        logic mosi;
        logic cs_n;
        logic hold_n;
        logic wp_n;
    } pins_t;

    localparam int PIN_W = $bits(pins_t);

    // cs_n resets low so a select already low at power-up shows no falling edge
    localparam pins_t PINS_RST = '{sclk: 1'b0, mosi: 1'b0, cs_n: 1'b0,
                                   hold_n: 1'b1, wp_n: 1'b1};

endpackage

// File: rtl/sfp_sync.sv
module sfp_sync #(
    parameter int              W       = 1,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = d_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.stg[i] = st_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= {STAGES{RST_VAL}};
        else        st_q <= st_d;
    end

    assign q_o = st_q.stg[STAGES-1];

endmodule

// File: rtl/sfp_ctrl.sv
module sfp_ctrl
    import sfp_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pin_s,
    input  logic  busy_i,
    output logic  rise_o,
    output logic  fall_o,
    output logic  start_o,
    output logic  stop_o,
    output logic  oe_o,
    output logic  standby_o
);
    typedef struct packed {
        logic sclk_prev;
        logic cs_n_prev;
        logic armed;
        logic sel;
        logic hold;
        logic oe;
        logic standby;
    } ctrl_t;

    ctrl_t c_d, c_q;
    logic  cs_fall, cs_rise, sclk_up, sclk_dn;

    always_comb begin
        c_d     = c_q;
        cs_fall = c_q.cs_n_prev & ~pin_s.cs_n;
        cs_rise = ~c_q.cs_n_prev & pin_s.cs_n;
        sclk_up = ~c_q.sclk_prev & pin_s.sclk;
        sclk_dn = c_q.sclk_prev & ~pin_s.sclk;

        c_d.sclk_prev = pin_s.sclk;
        c_d.cs_n_prev = pin_s.cs_n;
        // select must have been seen high at least once since reset
        c_d.armed     = c_q.armed | pin_s.cs_n;

        start_o = c_q.armed & cs_fall;
        stop_o  = c_q.sel & cs_rise;

        c_d.sel = ~pin_s.cs_n & (c_q.sel | start_o);

        // hold changes state only while the serial clock is low
        if (!c_d.sel)          c_d.hold = 1'b0;
        else if (!pin_s.sclk)  c_d.hold = ~pin_s.hold_n;

        rise_o = c_q.sel & ~c_q.hold & ~pin_s.cs_n & sclk_up;
        fall_o = c_q.sel & ~c_q.hold & ~pin_s.cs_n & sclk_dn;

        c_d.oe      = c_d.sel & ~c_d.hold;
        c_d.standby = pin_s.cs_n & ~busy_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign oe_o      = c_q.oe;
    assign standby_o = c_q.standby;

    a_r5_select_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.sel) |-> $past(c_q.armed));

    a_r7_hold_enters_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(c_q.hold) |-> $past(!pin_s.sclk));

endmodule

// File: rtl/sfp_shift.sv
module sfp_shift #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              mosi_i,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              start_o,
    output logic              abort_o,
    output logic              miso_o
);
    localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] rx_sh;
        logic [BYTE_W-1:0] rx_byte;
        logic              rx_valid;
        logic [BYTE_W-1:0] tx_sh;
        logic              miso;
        logic              start;
        logic              abort;
    } sh_t;

    sh_t s_d, s_q;
    logic [BYTE_W-1:0] rx_next;

    always_comb begin
        s_d          = s_q;
        s_d.rx_valid = 1'b0;
        s_d.start    = 1'b0;
        s_d.abort    = 1'b0;
        rx_next      = {s_q.rx_sh[BYTE_W-2:0], mosi_i};

        if (start_i) begin
            s_d.cnt   = '0;
            s_d.rx_sh = '0;
            s_d.tx_sh = '0;
            s_d.miso  = 1'b0;
            s_d.start = 1'b1;
        end else if (stop_i) begin
            s_d.abort = (s_q.cnt != '0);
            s_d.cnt   = '0;
        end else if (rise_i) begin
            s_d.rx_sh = rx_next;
            if (s_q.cnt == LAST) begin
                s_d.cnt      = '0;
                s_d.rx_byte  = rx_next;
                s_d.rx_valid = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (fall_i) begin
            if (s_q.cnt == '0) begin
                s_d.miso  = tx_byte_i[BYTE_W-1];
                s_d.tx_sh = tx_byte_i << 1;
            end else begin
                s_d.miso  = s_q.tx_sh[BYTE_W-1];
                s_d.tx_sh = s_q.tx_sh << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rx_byte_o  = s_q.rx_byte;
    assign rx_valid_o = s_q.rx_valid;
    assign start_o    = s_q.start;
    assign abort_o    = s_q.abort;
    assign miso_o     = s_q.miso;

    a_r1_byte_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.rx_valid |-> $past(rise_i));

    a_r2_miso_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.miso) |-> $past(fall_i || start_i));

    a_r9_abort_not_byte: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.abort |-> (!s_q.rx_valid && $past(stop_i)));

endmodule

// File: rtl/sfp_protect.sv
module sfp_protect #(
    parameter int BP_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic [BP_W-1:0] bp_i,
    input  logic            wp_n_i,
    output logic [BP_W-1:0] bp_o
);
    typedef struct packed {
        logic [BP_W-1:0] bp;
    } prot_t;

    prot_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (wr_i && wp_n_i) p_d.bp = bp_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    assign bp_o = p_q.bp;

    a_r10_locked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n_i |=> $stable(p_q.bp));

endmodule

// File: rtl/sflash_port_fe.sv
module sflash_port_fe
    import sfp_pkg::*;
#(
    parameter int BYTE_W      = 8,
    parameter int BP_W        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              mosi_i,
    input  logic              cs_n_i,
    input  logic              hold_n_i,
    input  logic              wp_n_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              busy_i,
    output logic              standby_o,
    input  logic [BYTE_W-1:0] tx_byte_i,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              rx_valid_o,
    output logic              frame_start_o,
    output logic              frame_abort_o,
    input  logic              sr_wr_i,
    input  logic [BP_W-1:0]   sr_bp_i,
    output logic [BP_W-1:0]   bp_o
);
    pins_t pin_raw, pin_s;
    logic  rise, fall, start, stop;

    always_comb begin
        pin_raw.sclk   = sclk_i;
        pin_raw.mosi   = mosi_i;
        pin_raw.cs_n   = cs_n_i;
        pin_raw.hold_n = hold_n_i;
        pin_raw.wp_n   = wp_n_i;
    end

    sfp_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_raw),
        .q_o   (pin_s)
    );

    sfp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_s     (pin_s),
        .busy_i    (busy_i),
        .rise_o    (rise),
        .fall_o    (fall),
        .start_o   (start),
        .stop_o    (stop),
        .oe_o      (miso_oe_o),
        .standby_o (standby_o)
    );

    sfp_shift #(.BYTE_W(BYTE_W)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .fall_i     (fall),
        .start_i    (start),
        .stop_i     (stop),
        .mosi_i     (pin_s.mosi),
        .tx_byte_i  (tx_byte_i),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o),
        .start_o    (frame_start_o),
        .abort_o    (frame_abort_o),
        .miso_o     (miso_o)
    );

    sfp_protect #(.BP_W(BP_W)) u_prot (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_i   (sr_wr_i),
        .bp_i   (sr_bp_i),
        .wp_n_i (pin_s.wp_n),
        .bp_o   (bp_o)
    );

    a_r3_oe_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        miso_oe_o |-> $past(!pin_s.cs_n));

    a_r7_no_edge_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (miso_oe_o == 1'b0 && $past(!pin_s.cs_n) && !pin_s.cs_n) |-> !(rise || fall));

endmodule

// File: tb/sflash_port_fe_tb.sv
module sflash_port_fe_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PH         = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk_i = 1'b0, mosi_i = 1'b0, cs_n_i = 1'b0;
    logic       hold_n_i = 1'b1, wp_n_i = 1'b1, busy_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic       sr_wr_i = 1'b0;
    logic [1:0] sr_bp_i = 2'b00;
    logic       miso_o, miso_oe_o, standby_o, rx_valid_o;
    logic       frame_start_o, frame_abort_o;
    logic [7:0] rx_byte_o;
    logic [1:0] bp_o;

    int n_checks = 0, n_fail = 0;
    int rx_cnt = 0, fs_cnt = 0, ab_cnt = 0;
    logic [7:0] last_rx = 8'h00;

    always #(CLK_PERIOD/2) clk = ~clk;

    sflash_port_fe u_dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .mosi_i(mosi_i),
        .cs_n_i(cs_n_i), .hold_n_i(hold_n_i), .wp_n_i(wp_n_i),
        .miso_o(miso_o), .miso_oe_o(miso_oe_o), .busy_i(busy_i),
        .standby_o(standby_o), .tx_byte_i(tx_byte_i), .rx_byte_o(rx_byte_o),
        .rx_valid_o(rx_valid_o), .frame_start_o(frame_start_o),
        .frame_abort_o(frame_abort_o), .sr_wr_i(sr_wr_i), .sr_bp_i(sr_bp_i),
        .bp_o(bp_o)
    );

    always @(posedge clk) begin
        if (rx_valid_o) begin rx_cnt <= rx_cnt + 1; last_rx <= rx_byte_o; end
        if (frame_start_o) fs_cnt <= fs_cnt + 1;
        if (frame_abort_o) ab_cnt <= ab_cnt + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int n);
        return 8'((n * 29 + 7) ^ 8'h5A);
    endfunction

    // one bit, clock idles low: data set, low phase, rise, high phase, fall
    task automatic spi_bit(input logic b, output logic got, output logic stable);
        logic m1;
        mosi_i = b;
        wait_clk(PH);
        got = miso_o;
        sclk_i = 1'b1;
        wait_clk(PH);
        m1 = miso_o;
        sclk_i = 1'b0;
        stable = (m1 == got);
    endtask

    task automatic xfer(input logic [7:0] out, input logic [7:0] next_tx,
                        input int hold_at, output logic [7:0] got, output logic stable);
        logic g, s;
        stable = 1'b1;
        for (int i = 0; i < 8; i++) begin
            if (i == hold_at) begin
                int rc;
                wait_clk(PH);
                hold_n_i = 1'b0;
                wait_clk(PH);
                check(miso_oe_o == 1'b0, "R7 oe during hold", miso_oe_o, 0);
                rc = rx_cnt;
                for (int k = 0; k < 3; k++) begin
                    mosi_i = ~mosi_i;
                    sclk_i = 1'b1; wait_clk(PH);
                    sclk_i = 1'b0; wait_clk(PH);
                end
                check(rx_cnt == rc, "R7 clocks ignored in hold", rx_cnt, rc);
                hold_n_i = 1'b1;
                wait_clk(PH);
                check(miso_oe_o == 1'b1, "R7 oe after hold", miso_oe_o, 1);
            end
            spi_bit(out[7-i], g, s);
            got[7-i] = g;
            stable &= s;
            if (i == 0) tx_byte_i = next_tx;
        end
        wait_clk(PH);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        logic [7:0] got;
        logic       st, g, s;
        int         rc, fc, ac;

        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(6);
        // R11 reset state (select already low from power-up)
        check(bp_o == 2'b00, "R11 bp reset", bp_o, 0);
        check(miso_oe_o == 1'b0, "R11 oe reset", miso_oe_o, 0);
        check(rx_cnt == 0 && fs_cnt == 0 && ab_cnt == 0, "R11 strobes reset", rx_cnt + fs_cnt + ab_cnt, 0);

        // R5 select low since reset: a full byte is refused
        xfer(8'hFF, 8'h00, -1, got, st);
        check(rx_cnt == 0, "R5 no byte before arming", rx_cnt, 0);
        check(fs_cnt == 0, "R5 no frame before arming", fs_cnt, 0);
        check(miso_oe_o == 1'b0, "R5 no drive before arming", miso_oe_o, 0);
        cs_n_i = 1'b1; wait_clk(PH);
        check(standby_o == 1'b1, "R4 standby deselected idle", standby_o, 1);
        busy_i = 1'b1; wait_clk(PH);
        check(standby_o == 1'b0, "R4 standby while busy", standby_o, 0);
        busy_i = 1'b0; wait_clk(PH);
        check(miso_oe_o == 1'b0, "R3 hiz deselected", miso_oe_o, 0);

        // R8 hold while deselected does nothing
        hold_n_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            sclk_i = 1'b1; wait_clk(PH); sclk_i = 1'b0; wait_clk(PH);
        end
        check(standby_o == 1'b1, "R8 standby kept", standby_o, 1);
        check(miso_oe_o == 1'b0 && rx_cnt == 0, "R8 no activity", rx_cnt, 0);
        hold_n_i = 1'b1; wait_clk(PH);

        // R1/R2/R6 sweep of all byte values in one frame
        cs_n_i = 1'b0; wait_clk(PH);
        check(fs_cnt == 1, "R6 frame start", fs_cnt, 1);
        check(miso_oe_o == 1'b1, "R3 drive when selected", miso_oe_o, 1);
        check(standby_o == 1'b0, "R4 active when selected", standby_o, 0);
        xfer(8'hA5, pat(0), -1, got, st);
        check(last_rx == 8'hA5 && rx_cnt == 1, "R1 first byte", last_rx, 8'hA5);
        check(got == 8'h00, "R2 first byte reads zero", got, 0);
        for (int n = 0; n < 256; n++) begin
            rc = rx_cnt;
            xfer(8'(n), pat(n + 1), -1, got, st);
            check(last_rx == 8'(n) && rx_cnt == rc + 1, "R1 sweep rx", last_rx, n);
            check(got == pat(n), "R2 sweep tx", got, pat(n));
            check(st, "R2 stable while clock high", st, 1);
        end
        cs_n_i = 1'b1; wait_clk(PH);
        check(ab_cnt == 0, "R9 boundary end no abort", ab_cnt, 0);
        check(miso_oe_o == 1'b0, "R3 hiz after frame", miso_oe_o, 0);

        // R7 hold in the middle of a byte
        cs_n_i = 1'b0; wait_clk(PH);
        xfer(8'h11, 8'hC3, -1, got, st);
        xfer(8'h96, 8'h00, 4, got, st);
        check(last_rx == 8'h96, "R7 rx across hold", last_rx, 8'h96);
        check(got == 8'hC3, "R7 tx across hold", got, 8'hC3);
        cs_n_i = 1'b1; wait_clk(PH);

        // R9 abort mid byte, then R6 counter restart
        cs_n_i = 1'b0; wait_clk(PH);
        rc = rx_cnt; ac = ab_cnt;
        for (int i = 0; i < 3; i++) spi_bit(1'b1, g, s);
        wait_clk(PH);
        cs_n_i = 1'b1; wait_clk(PH);
        check(ab_cnt == ac + 1, "R9 abort pulse", ab_cnt, ac + 1);
        check(rx_cnt == rc, "R9 no partial byte", rx_cnt, rc);
        fc = fs_cnt;
        cs_n_i = 1'b0; wait_clk(PH);
        check(fs_cnt == fc + 1, "R6 new frame start", fs_cnt, fc + 1);
        xfer(8'h3C, 8'h00, -1, got, st);
        check(last_rx == 8'h3C, "R6 counter restarted", last_rx, 8'h3C);
        cs_n_i = 1'b1; wait_clk(PH);

        // R10 write protect sweep
        for (int v = 0; v < 4; v++) begin
            wp_n_i = 1'b1; wait_clk(4);
            sr_bp_i = 2'(v); sr_wr_i = 1'b1; wait_clk(1); sr_wr_i = 1'b0; wait_clk(2);
            check(bp_o == 2'(v), "R10 write unlocked", bp_o, v);
            wp_n_i = 1'b0; wait_clk(4);
            sr_bp_i = ~2'(v); sr_wr_i = 1'b1; wait_clk(1); sr_wr_i = 1'b0; wait_clk(2);
            check(bp_o == 2'(v), "R10 write locked", bp_o, v);
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule